// File: doc/BRIEF.md
# Frame Alignment Measurement Unit

This unit measures how late a selected frame evaluation line falls relative to the frame pulse. Twenty-four evaluation lines come in alongside the active-low frame pulse. A binary select field picks one of the lines. The measurement runs in master clock periods. Each falling edge of the frame pulse marks a frame boundary.

Software first holds the start control low for at least one complete frame. It then raises the start control. The first frame boundary after the rise opens a one-frame measurement window. The unit records how many master clock periods pass from that boundary to the first falling edge of the selected line. At the next frame boundary it latches the 10-bit result and raises the done flag. If the selected line does not fall during the window, or the count exceeds the field, the result reads as all ones. Lowering the start control clears the done flag and prepares the unit for the next cycle.

Top module: `frame_align_meas`

## Requirements
- R1: `sel_i` is a binary index. Values 0 to 23 select `eval_i[sel_i]`. Values 24 to 31 select no line, and the measurement then completes with result 1023.
- R2: A rise of `start_i` starts a measurement only if `start_i` was low across at least one full frame, meaning two frame-pulse falling edges were seen while it was low. A rise that does not meet this starts nothing.
- R3: The measurement window opens at the first falling edge of `frame_i` after an accepted start rise. `done_o` rises in the clock cycle after the next falling edge of `frame_i`, one frame later.
- R4: `offset_o` counts the clock edges from the edge that samples `frame_i` falling to the edge that samples the selected line falling. When both are sampled at the same edge, the result is 0.
- R5: Only the first falling edge of the selected line inside the window is counted.
- R6: If the selected line does not fall inside the window, `done_o` still rises and `offset_o` reads 1023.
- R7: The count saturates at 1023 in frames longer than 1023 clocks.
- R8: While `start_i` stays high, `done_o` and `offset_o` hold their values. The clock edge that samples `start_i` low clears `done_o`. `offset_o` keeps the last result.
- R9: While `rst_ni` is low, `done_o` reads 0 and `offset_o` reads 0.
- R10: If `start_i` goes low before the window closes, the measurement is dropped and `done_o` does not rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Frame pulse, active low; its falling edge marks a frame boundary |
| eval_i | input | 24 | Frame evaluation lines |
| sel_i | input | 5 | Binary index of the line to measure |
| start_i | input | 1 | Start control; a rise starts a measurement once armed |
| done_o | output | 1 | Result ready |
| offset_o | output | 10 | Measured offset in master clock periods |

## Verification
The selected line falls at many different positions in the frame: at the frame boundary itself, a few clocks after it, and on the last clock before the next boundary. These cases separate an off-by-one in the counter from a correct count. The other lines fall at a fixed decoy position, so routing the wrong line shows up as a wrong count. Further patterns cover a second fall inside the window, no fall at all, an out-of-range index, and a frame longer than the counter range. These separate first-edge capture, the timeout value, and saturation. Directed runs also cover a start rise that is not armed and a start that drops during the window.

// File: rtl/fam_pkg.sv
package fam_pkg;
  localparam int N_EVAL = 24;
  localparam int SEL_W  = 5;
  localparam int OFS_W  = 10;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_MEAS,
    ST_DONE
  } fam_state_e;
endpackage

// File: rtl/fam_fall_det.sv
module fam_fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic fall_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign fall_o = sig_q & ~sig_i;
endmodule

// File: rtl/fam_eval_mux.sv
module fam_eval_mux #(
  parameter int N_EVAL = 24,
  parameter int SEL_W  = 5
) (
  input  logic [N_EVAL-1:0] eval_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              line_o
);
  logic [N_EVAL-1:0] low_hit;

  for (genvar g = 0; g < N_EVAL; g++) begin : g_line
    assign low_hit[g] = (sel_i == SEL_W'(g)) & ~eval_i[g];
  end

  // out-of-range index reads as a line that never falls
  assign line_o = ~|low_hit;
endmodule

// File: rtl/fam_arm_ctl.sv
module fam_arm_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic fp_fall_i,
  output logic trig_o
);
  logic       start_q;
  logic [1:0] low_edges;
  logic       armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q   <= 1'b0;
      low_edges <= 2'd0;
    end else begin
      start_q <= start_i;
      if (start_i)                           low_edges <= 2'd0;
      else if (fp_fall_i && low_edges != 2'd2) low_edges <= low_edges + 2'd1;
    end
  end

  // two boundaries seen while low = one whole frame low
  assign armed  = (low_edges == 2'd2);
  assign trig_o = start_i & ~start_q & armed;
endmodule

// File: rtl/fam_meas_core.sv
module fam_meas_core
  import fam_pkg::*;
#(
  parameter int OFS_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             start_i,
  input  logic             fp_fall_i,
  input  logic             ev_fall_i,
  output logic             done_o,
  output logic [OFS_W-1:0] ofs_o
);
  localparam logic [OFS_W-1:0] OFS_MAX = '1;

  fam_state_e       state;
  logic [OFS_W-1:0] cnt, cnt_inc, cap;
  logic             hit;

  assign cnt_inc = (cnt == OFS_MAX) ? cnt : cnt + OFS_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      cap    <= '0;
      hit    <= 1'b0;
      done_o <= 1'b0;
      ofs_o  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (trig_i) state <= ST_WAIT;
        ST_WAIT: begin
          if (!start_i) state <= ST_IDLE;
          else if (fp_fall_i) begin
            state <= ST_MEAS;
            cnt   <= '0;
            cap   <= '0;
            hit   <= ev_fall_i;
          end
        end
        ST_MEAS: begin
          if (!start_i) state <= ST_IDLE;
          else if (fp_fall_i) begin
            state  <= ST_DONE;
            done_o <= 1'b1;
            ofs_o  <= hit ? cap : OFS_MAX;
          end else begin
            cnt <= cnt_inc;
            if (ev_fall_i && !hit) begin
              hit <= 1'b1;
              cap <= cnt_inc;
            end
          end
        end
        ST_DONE: begin
          if (!start_i) begin
            state  <= ST_IDLE;
            done_o <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/frame_align_meas.sv
module frame_align_meas
  import fam_pkg::*;
#(
  parameter int N_EVAL_P = N_EVAL,
  parameter int SEL_W_P  = SEL_W,
  parameter int OFS_W_P  = OFS_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                frame_i,
  input  logic [N_EVAL_P-1:0] eval_i,
  input  logic [SEL_W_P-1:0]  sel_i,
  input  logic                start_i,
  output logic                done_o,
  output logic [OFS_W_P-1:0]  offset_o
);
  logic fp_fall, ev_line, ev_fall, trig;

  fam_fall_det u_fp_det (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (frame_i),
    .fall_o(fp_fall)
  );

  fam_eval_mux #(
    .N_EVAL(N_EVAL_P),
    .SEL_W (SEL_W_P)
  ) u_mux (
    .eval_i(eval_i),
    .sel_i (sel_i),
    .line_o(ev_line)
  );

  fam_fall_det u_ev_det (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (ev_line),
    .fall_o(ev_fall)
  );

  fam_arm_ctl u_arm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .fp_fall_i(fp_fall),
    .trig_o   (trig)
  );

  fam_meas_core #(
    .OFS_W(OFS_W_P)
  ) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .trig_i   (trig),
    .start_i  (start_i),
    .fp_fall_i(fp_fall),
    .ev_fall_i(ev_fall),
    .done_o   (done_o),
    .ofs_o    (offset_o)
  );
endmodule

// File: rtl/fam_chk.sv
module fam_chk #(
  parameter int OFS_W_P = 10
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               frame_i,
  input logic               start_i,
  input logic               done_o,
  input logic [OFS_W_P-1:0] offset_o
);
  // R3: done rises right after a frame pulse falling edge
  p_done_at_boundary_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (!$past(frame_i) && $past(frame_i, 2)));

  // R3: done only rises while start is held high
  p_done_needs_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(start_i));

  // R8: start low clears done on the next edge
  p_clear_on_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o);

  // R8: result holds while done stays high
  p_hold_result_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(done_o)) |-> $stable(offset_o));

  // R9: reset state
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_state_r9: assert (!done_o && offset_o == '0);
    end
  end
endmodule

bind frame_align_meas fam_chk #(.OFS_W_P(OFS_W_P)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .frame_i (frame_i),
  .start_i (start_i),
  .done_o  (done_o),
  .offset_o(offset_o)
);

// File: tb/sim_frame_align_meas.sv
`timescale 1ns/1ps
module sim_frame_align_meas;
  typedef struct packed {
    int sel;
    int d1;
    int d2;
    int exp;
  } vec_t;

  localparam int NV = 8;
  localparam int DECOY = 30;
  localparam vec_t VECS [NV] = '{
    '{0,  3,  -1, 3},     // R4 short lag
    '{23, 17, -1, 17},    // R1 top index
    '{12, 0,  -1, 0},     // R4 same edge
    '{7,  63, -1, 63},    // R4 last clock in frame
    '{5,  20, 40, 20},    // R5 first edge only
    '{9,  -1, -1, 1023},  // R6 no fall
    '{27, 10, -1, 1023},  // R1 out-of-range index
    '{1,  31, -1, 31}     // R1 next to decoy position
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        frame_i = 1'b1;
  logic [23:0] eval_i = '1;
  logic [4:0]  sel_i = '0;
  logic        start_i = 1'b0;
  logic        done_o;
  logic [9:0]  offset_o;

  int frame_len = 64;
  int pos = 0;
  int cur_sel = 0, cur_d1 = -1, cur_d2 = -1;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  frame_align_meas u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_i(frame_i), .eval_i(eval_i),
    .sel_i(sel_i), .start_i(start_i), .done_o(done_o), .offset_o(offset_o)
  );

  // frame and evaluation line generator
  initial begin
    forever begin
      @(negedge clk_i);
      pos = (pos + 1 >= frame_len) ? 0 : pos + 1;
      frame_i = (pos != 0);
      sel_i = 5'(cur_sel);
      for (int ch = 0; ch < 24; ch++) begin
        if (ch == cur_sel) eval_i[ch] = !(pos == cur_d1 || pos == cur_d2);
        else               eval_i[ch] = (pos != DECOY);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic arm_low();
    start_i = 1'b0;
    repeat (2 * frame_len + 4) @(negedge clk_i);
  endtask

  task automatic run_vec(input int sel, input int d1, input int d2, input int exp);
    int n;
    cur_sel = sel; cur_d1 = d1; cur_d2 = d2;
    arm_low();
    start_i = 1'b1;
    n = 0;
    while (!done_o && n < 3 * frame_len + 4) begin
      @(negedge clk_i);
      n++;
    end
    // R3: done within one frame of the window opening
    check("R3 done timing", int'(done_o && n >= frame_len + 1 && n <= 2 * frame_len + 1), 1);
    check("R4 offset", int'(offset_o), exp);
  endtask

  task automatic wait_pos(input int p);
    do begin
      @(negedge clk_i);
      #1;
    end while (pos != p);
  endtask

  initial begin
    int held;
    repeat (3) @(negedge clk_i);
    check("R9 reset done", int'(done_o), 0);
    check("R9 reset offset", int'(offset_o), 0);
    rst_ni = 1'b1;

    for (int v = 0; v < NV; v++)
      run_vec(VECS[v].sel, VECS[v].d1, VECS[v].d2, VECS[v].exp);

    // R8 hold while start high, then clear
    held = int'(offset_o);
    repeat (frame_len + 3) @(negedge clk_i);
    check("R8 done held", int'(done_o), 1);
    check("R8 offset held", int'(offset_o), held);
    start_i = 1'b0;
    repeat (2) @(negedge clk_i);
    check("R8 done cleared", int'(done_o), 0);
    check("R8 offset kept", int'(offset_o), held);

    // R2 rise without a full low frame is ignored
    cur_sel = 2; cur_d1 = 8; cur_d2 = -1;
    repeat (10) @(negedge clk_i);
    start_i = 1'b1;
    repeat (3 * frame_len + 4) @(negedge clk_i);
    check("R2 unarmed rise ignored", int'(done_o), 0);

    // R10 start dropped inside the window
    arm_low();
    cur_d1 = 40;
    wait_pos(10);
    start_i = 1'b1;
    wait_pos(0);
    wait_pos(32);
    start_i = 1'b0;
    @(negedge clk_i);
    start_i = 1'b1;
    repeat (3 * frame_len + 4) @(negedge clk_i);
    check("R10 aborted no done", int'(done_o), 0);

    // R7 long frame: count beyond 64, then saturation
    start_i = 1'b0;
    frame_len = 1100;
    run_vec(4, 700, -1, 700);
    run_vec(4, 1050, -1, 1023);
    check("R7 saturated", int'(offset_o), 1023);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule